// File: doc/BRIEF.md
# Signal-Aware Bytecode Process Core

This block is a small multicycle processor that runs a single process of a compiled hardware-description bytecode program directly in fabric. A host fills a local instruction memory with code words through a memory-mapped window, then writes a start command. The core runs from word 0 through a fixed sequence of states: FETCH, DECODE, EXEC and, for signal operations, SIGW. When it meets the end-of-process instruction it enters DONE and raises `done`. A later start command runs the same code again.

Besides register arithmetic, immediate add, word load and store, two conditional branches and a jump, the core has two signal operations. SRD copies a named signal into a register. SWR sends a register value to a named signal. In both cases the value is cut to the declared width of the signal, which is carried in the instruction. A signal access holds the machine in SIGW until the signal port acknowledges.

States and transitions. IDLE goes to LOAD on a load command, or to FETCH on a start command. LOAD goes to FETCH on start. FETCH goes to DECODE, and DECODE goes to EXEC. EXEC goes to SIGW for a signal operation, to DONE for the end instruction, and to FETCH for anything else. SIGW goes to FETCH on `sig_ack`. DONE goes to FETCH on start, or to LOAD on a load command.

Top module: `sigproc_core`

## Requirements
- R1: After reset the core is idle: `done` = 0, `sig_req` = 0, and the status word reads 0.
- R2: A host write with `host_addr[IM_AW]` = 1 stores `host_wdata` as the code word at index `host_addr[IM_AW-1:0]`. This happens only while in LOAD; such writes in any other state leave the code unchanged. A control write (`host_addr[IM_AW]` = 0) with bit 1 set enters LOAD from IDLE or DONE.
- R3: A control write with bit 0 set, made in IDLE, LOAD or DONE, starts execution at code word 0 and clears `done`. The core then reads busy. A start written while the core is running is ignored.
- R4: Instruction fields are op = [31:26], rs = [25:21], rt = [20:16], rd = [15:11], funct = [5:0] and imm = [15:0]. With op 0, funct 0x20/0x22/0x24/0x25 writes rs+rt, rs−rt, rs&rt or rs|rt into rd. Op 0x08 writes rs + sign-extended imm into rt.
- R5: Register 0 always reads as zero, and writes to it are discarded.
- R6: Op 0x2B stores rt and op 0x23 loads rt. Both use the byte address rs + sign-extended imm, and bits [DM_AW+1:2] of that address select the data word.
- R7: Op 0x05 (not equal) and op 0x04 (equal) branch to the index of the next word plus the sign-extended imm when their test holds. Op 0x02 jumps to the word index in bits [IM_AW-1:0].
- R8: Op 0x30 raises `sig_req` with `sig_wr` = 0 and `sig_id` = imm[SIG_IDW-1:0], and holds in SIGW until `sig_ack`. It then writes `sig_rdata` into rt, keeping only the low (rs field + 1) bits.
- R9: Op 0x31 raises `sig_req` with `sig_wr` = 1 and the same id. `sig_wdata` is rt cut to (rs field + 1) bits. The request and its fields stay stable until `sig_ack`, and one acknowledge completes exactly one access.
- R10: Op 0x3F ends the activation: the core enters DONE, `done` = 1, and no further signal request is made.
- R11: A read with `host_addr[IM_AW]` = 0 returns status, with bit 0 = busy and bit 1 = done.
- R12: An unassigned opcode, or an unassigned funct with op 0, changes no register and no memory and proceeds to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | IM_AW+1 | Host address: top bit selects the code window, clear selects control/status |
| host_wdata | input | 32 | Host write data (code word or command bits) |
| host_rdata | output | 32 | Status word for control-space reads |
| done | output | 1 | Activation finished |
| sig_req | output | 1 | Signal access request |
| sig_wr | output | 1 | 1 = signal write, 0 = signal read |
| sig_id | output | SIG_IDW | Signal identifier |
| sig_wdata | output | 32 | Width-cut signal write value |
| sig_rdata | input | 32 | Signal read value, taken with `sig_ack` |
| sig_ack | input | 1 | Access complete |

## Verification
The bench builds the core with IM_AW = 5, DM_AW = 4 and SIG_IDW = 4. A 32-word program space is enough for a countdown loop, both branch kinds and a forward jump in a single program. The 16-word data memory is enough for a store/load round trip. The signal responder adds an acknowledge delay, which keeps the core in SIGW for several cycles. A start written during that wait should be ignored, so the bench can check that it leaves the stream of signal writes unchanged. Widths of 4, 8 and 32 bits exercise the width cut on both reads and writes.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int XLEN = 32;
    typedef logic [XLEN-1:0] word_t;

    typedef enum logic [2:0] {
        S_IDLE, S_LOAD, S_FETCH, S_DECODE, S_EXEC, S_SIGW, S_DONE
    } state_t;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR} alu_op_t;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_BNE   = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_SRD   = 6'h30;
    localparam logic [5:0] OP_SWR   = 6'h31;
    localparam logic [5:0] OP_END   = 6'h3F;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/sp_regfile.sv
module sp_regfile #(
    parameter int NREG = 32,
    parameter int DW   = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra1,
    output logic [DW-1:0] rd1,
    input  logic [AW-1:0] ra2,
    output logic [DW-1:0] rd2
);
    logic [DW-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/sp_mem.sv
module sp_mem #(
    parameter int AW = 6,
    parameter int DW = 32,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[wa] <= wd;
    end

    assign rd = cells[ra];
endmodule

// File: rtl/sp_alu.sv
module sp_alu
    import sp_pkg::*;
(
    input  alu_op_t op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end
endmodule

// File: rtl/sigproc_core.sv
module sigproc_core
    import sp_pkg::*;
#(
    parameter int IM_AW   = 6,
    parameter int DM_AW   = 6,
    parameter int SIG_IDW = 8,
    localparam int HA_W   = IM_AW + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HA_W-1:0]    host_addr,
    input  logic [XLEN-1:0]    host_wdata,
    output logic [XLEN-1:0]    host_rdata,
    output logic               done,
    output logic               sig_req,
    output logic               sig_wr,
    output logic [SIG_IDW-1:0] sig_id,
    output logic [XLEN-1:0]    sig_wdata,
    input  logic [XLEN-1:0]    sig_rdata,
    input  logic               sig_ack
);
    state_t             st, st_nx;
    logic [IM_AW-1:0]   pc, pc_nx, pc_inc, pc_br;
    word_t              ir, opa, opb;
    word_t              imem_q, dm_q, rf_a, rf_b, alu_b, alu_y, rf_wd, wmask;
    logic               rf_we, dm_we, busy, taken, rtype_ok;
    logic [4:0]         rf_wa;
    alu_op_t            alu_sel;

    // host command decode
    logic code_wr, ctrl_wr, cmd_start, cmd_load;
    assign code_wr   = host_we && host_addr[HA_W-1] && (st == S_LOAD);
    assign ctrl_wr   = host_we && !host_addr[HA_W-1];
    assign cmd_start = ctrl_wr && host_wdata[0];
    assign cmd_load  = ctrl_wr && host_wdata[1];

    // instruction fields
    logic [5:0]  op, funct;
    logic [4:0]  rs, rt, rd, wfld;
    logic [15:0] imm;
    assign op    = ir[31:26];
    assign rs    = ir[25:21];
    assign rt    = ir[20:16];
    assign rd    = ir[15:11];
    assign funct = ir[5:0];
    assign imm   = ir[15:0];
    assign wfld  = ir[25:21];

    sp_mem #(.AW(IM_AW), .DW(XLEN)) u_imem (
        .clk(clk), .we(code_wr), .wa(host_addr[IM_AW-1:0]), .wd(host_wdata),
        .ra(pc), .rd(imem_q)
    );

    sp_regfile #(.NREG(32), .DW(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .wa(rf_wa), .wd(rf_wd),
        .ra1(rs), .rd1(rf_a), .ra2(rt), .rd2(rf_b)
    );

    sp_alu u_alu (.op(alu_sel), .a(opa), .b(alu_b), .y(alu_y));

    sp_mem #(.AW(DM_AW), .DW(XLEN)) u_dmem (
        .clk(clk), .we(dm_we), .wa(alu_y[DM_AW+1:2]), .wd(opb),
        .ra(alu_y[DM_AW+1:2]), .rd(dm_q)
    );

    assign pc_inc = pc + 1'b1;
    assign pc_br  = pc_inc + imm[IM_AW-1:0];
    assign taken  = (op == OP_BNE) ? (opa != opb) : (opa == opb);
    assign wmask  = {XLEN{1'b1}} >> (5'd31 - wfld);
    assign busy   = (st == S_FETCH) || (st == S_DECODE) || (st == S_EXEC) || (st == S_SIGW);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            pc  <= '0;
            ir  <= '0;
            opa <= '0;
            opb <= '0;
        end else begin
            st <= st_nx;
            pc <= pc_nx;
            if (st == S_FETCH)  ir <= imem_q;
            if (st == S_DECODE) begin
                opa <= rf_a;
                opb <= rf_b;
            end
        end
    end

    // next state
    always_comb begin
        st_nx = st;
        pc_nx = pc;
        unique case (st)
            S_IDLE, S_DONE: begin
                if (cmd_start) begin
                    st_nx = S_FETCH;
                    pc_nx = '0;
                end else if (cmd_load) begin
                    st_nx = S_LOAD;
                end
            end
            S_LOAD: if (cmd_start) begin
                st_nx = S_FETCH;
                pc_nx = '0;
            end
            S_FETCH:  st_nx = S_DECODE;
            S_DECODE: st_nx = S_EXEC;
            S_EXEC: begin
                st_nx = S_FETCH;
                if (op == OP_SRD || op == OP_SWR) st_nx = S_SIGW;
                else if (op == OP_END)            st_nx = S_DONE;
                else if (op == OP_J)              pc_nx = ir[IM_AW-1:0];
                else if (op == OP_BNE || op == OP_BEQ) pc_nx = taken ? pc_br : pc_inc;
                else                              pc_nx = pc_inc;
            end
            S_SIGW: if (sig_ack) begin
                st_nx = S_FETCH;
                pc_nx = pc_inc;
            end
            default: st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        alu_b   = (op == OP_RTYPE) ? opb : sext16(imm);
        alu_sel = ALU_ADD;
        rtype_ok = 1'b0;
        if (op == OP_RTYPE) begin
            unique case (funct)
                FN_ADD: begin alu_sel = ALU_ADD; rtype_ok = 1'b1; end
                FN_SUB: begin alu_sel = ALU_SUB; rtype_ok = 1'b1; end
                FN_AND: begin alu_sel = ALU_AND; rtype_ok = 1'b1; end
                FN_OR:  begin alu_sel = ALU_OR;  rtype_ok = 1'b1; end
                default: alu_sel = ALU_ADD;
            endcase
        end
        rf_we = 1'b0;
        rf_wa = rt;
        rf_wd = alu_y;
        dm_we = 1'b0;
        if (st == S_EXEC) begin
            if (op == OP_RTYPE && rtype_ok) begin
                rf_we = 1'b1;
                rf_wa = rd;
            end else if (op == OP_ADDI) begin
                rf_we = 1'b1;
            end else if (op == OP_LW) begin
                rf_we = 1'b1;
                rf_wd = dm_q;
            end else if (op == OP_SW) begin
                dm_we = 1'b1;
            end
        end else if (st == S_SIGW && sig_ack && op == OP_SRD) begin
            rf_we = 1'b1;
            rf_wd = sig_rdata & wmask;
        end
        sig_req    = (st == S_SIGW);
        sig_wr     = (op == OP_SWR);
        sig_id     = imm[SIG_IDW-1:0];
        sig_wdata  = opb & wmask;
        done       = (st == S_DONE);
        host_rdata = host_addr[HA_W-1] ? '0 : {{(XLEN-2){1'b0}}, done, busy};
    end

    // request fields are held until acknowledged
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_req && !sig_ack) |=> (sig_req && $stable(sig_id) && $stable(sig_wr) && $stable(sig_wdata)));

    // an acknowledge completes exactly one access
    p_ack_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_req && sig_ack) |=> !sig_req);

    // a finished activation makes no signal request
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sig_req);

    // restart from DONE begins at word 0 with done cleared
    p_start_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_DONE && cmd_start) |=> (st == S_FETCH && pc == '0 && !done));
endmodule

// File: tb/sim_sigproc_core.sv
module sim_sigproc_core;
    localparam int CLK_PERIOD = 10;
    localparam int IM_AW = 5;
    localparam int DM_AW = 4;
    localparam int SIG_IDW = 4;
    localparam int HA_W = IM_AW + 1;

    logic clk = 1'b0;
    logic rst_n;
    logic host_we;
    logic [HA_W-1:0] host_addr;
    logic [31:0] host_wdata, host_rdata;
    logic done, sig_req, sig_wr, sig_ack;
    logic [SIG_IDW-1:0] sig_id;
    logic [31:0] sig_wdata, sig_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int ack_delay = 0;
    int wait_cnt = 0;
    logic [31:0] sig_vals [16];
    logic [63:0] exp_q [$];
    string tag_q [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sigproc_core #(.IM_AW(IM_AW), .DM_AW(DM_AW), .SIG_IDW(SIG_IDW)) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .done(done),
        .sig_req(sig_req), .sig_wr(sig_wr), .sig_id(sig_id), .sig_wdata(sig_wdata),
        .sig_rdata(sig_rdata), .sig_ack(sig_ack)
    );

    function automatic logic [31:0] e_r(input logic [5:0] fn, input int s, input int t, input int d);
        return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction
    function automatic logic [31:0] e_i(input logic [5:0] op, input int s, input int t, input int imm);
        return {op, 5'(s), 5'(t), 16'(imm)};
    endfunction
    function automatic logic [31:0] e_sig(input logic [5:0] op, input int t, input int id, input int w);
        return {op, 5'(w - 1), 5'(t), 16'(id)};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [HA_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_addr = '0;
    endtask

    task automatic expect_wr(input int id, input logic [31:0] v, input string tag);
        exp_q.push_back({32'(id), v});
        tag_q.push_back(tag);
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(req, {31'd0, done}, 32'd1);
    endtask

    // signal responder and scoreboard monitor
    initial begin
        sig_ack = 1'b0;
        sig_rdata = '0;
        forever begin
            @(negedge clk);
            if (sig_ack) begin
                sig_ack = 1'b0;
            end else if (sig_req) begin
                if (wait_cnt >= ack_delay) begin
                    wait_cnt = 0;
                    sig_ack = 1'b1;
                    if (sig_wr) begin
                        if (exp_q.size() == 0) begin
                            n_chk++; n_bad++;
                            $display("FAIL R9: unexpected write id %0d actual 0x%08h expected none", sig_id, sig_wdata);
                        end else begin
                            logic [63:0] e;
                            string t;
                            e = exp_q.pop_front();
                            t = tag_q.pop_front();
                            check(t, {28'd0, sig_id}, e[63:32]);
                            check(t, sig_wdata, e[31:0]);
                        end
                    end else begin
                        sig_rdata = sig_vals[sig_id];
                    end
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic load_p2();
        host_wr(6'h00, 32'h2);
        host_wr({1'b1, 5'd0},  e_sig(6'h30, 1, 7, 8));      // R8 read, 8 bits
        host_wr({1'b1, 5'd1},  e_i(6'h2B, 0, 1, 8));        // R6 store
        host_wr({1'b1, 5'd2},  e_i(6'h23, 0, 2, 8));        // R6 load
        host_wr({1'b1, 5'd3},  e_sig(6'h31, 2, 1, 32));
        host_wr({1'b1, 5'd4},  e_i(6'h08, 0, 3, 3));
        host_wr({1'b1, 5'd5},  e_i(6'h08, 3, 3, -1));
        host_wr({1'b1, 5'd6},  e_sig(6'h31, 3, 2, 32));
        host_wr({1'b1, 5'd7},  e_i(6'h05, 3, 0, -3));       // R7 bne back
        host_wr({1'b1, 5'd8},  e_i(6'h04, 0, 0, 1));        // R7 beq skip
        host_wr({1'b1, 5'd9},  e_sig(6'h31, 1, 9, 32));
        host_wr({1'b1, 5'd10}, {6'h02, 26'd12});            // R7 jump
        host_wr({1'b1, 5'd11}, e_sig(6'h31, 1, 9, 32));
        host_wr({1'b1, 5'd12}, e_sig(6'h31, 1, 3, 32));
        host_wr({1'b1, 5'd13}, {6'h3F, 26'd0});
    endtask

    task automatic expect_p2();
        expect_wr(1, 32'hA5, "R8 R6 read cut and load");
        expect_wr(2, 32'd2, "R7 loop 2");
        expect_wr(2, 32'd1, "R7 loop 1");
        expect_wr(2, 32'd0, "R7 loop 0");
        expect_wr(3, 32'hA5, "R7 branch/jump skip");
    endtask

    initial begin
        rst_n = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
        for (int i = 0; i < 16; i++) sig_vals[i] = 32'h0;
        sig_vals[7] = 32'h0000_01A5;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", {31'd0, done}, 32'd0);
        check("R1 sig_req", {31'd0, sig_req}, 32'd0);
        check("R1 R11 status", host_rdata, 32'd0);

        // program 1: arithmetic, r0, width cut, unknown op
        host_wr(6'h00, 32'h2);
        host_wr({1'b1, 5'd0},  e_i(6'h08, 0, 1, 5));
        host_wr({1'b1, 5'd1},  e_i(6'h08, 0, 2, -3));
        host_wr({1'b1, 5'd2},  e_r(6'h20, 1, 2, 3));
        host_wr({1'b1, 5'd3},  e_r(6'h22, 1, 2, 4));
        host_wr({1'b1, 5'd4},  e_r(6'h24, 1, 2, 5));
        host_wr({1'b1, 5'd5},  e_r(6'h25, 1, 2, 6));
        host_wr({1'b1, 5'd6},  e_i(6'h08, 0, 0, 7));        // R5 write r0
        host_wr({1'b1, 5'd7},  e_i(6'h3A, 0, 3, 99));       // R12 unknown op
        host_wr({1'b1, 5'd8},  e_r(6'h3E, 1, 2, 4));        // R12 unknown funct
        host_wr({1'b1, 5'd9},  e_sig(6'h31, 3, 1, 32));
        host_wr({1'b1, 5'd10}, e_sig(6'h31, 4, 2, 32));
        host_wr({1'b1, 5'd11}, e_sig(6'h31, 5, 3, 32));
        host_wr({1'b1, 5'd12}, e_sig(6'h31, 6, 4, 32));
        host_wr({1'b1, 5'd13}, e_sig(6'h31, 0, 5, 32));
        host_wr({1'b1, 5'd14}, e_sig(6'h31, 2, 6, 4));
        host_wr({1'b1, 5'd15}, {6'h3F, 26'd0});
        expect_wr(1, 32'd2, "R4 add R12");
        expect_wr(2, 32'd8, "R4 sub R12");
        expect_wr(3, 32'd5, "R4 and");
        expect_wr(4, 32'hFFFF_FFFD, "R4 or");
        expect_wr(5, 32'd0, "R5 zero reg");
        expect_wr(6, 32'hD, "R9 width cut");
        host_wr(6'h00, 32'h1);
        check("R3 R11 busy after start", host_rdata, 32'd1);
        wait_done("R10 done p1");
        @(negedge clk);
        check("R10 R11 status done", host_rdata, 32'd2);
        check("R10 no request", {31'd0, sig_req}, 32'd0);
        check("R9 all p1 writes seen", exp_q.size(), 32'd0);

        // program 2 with slow acknowledge and a start while running
        ack_delay = 4;
        load_p2();
        expect_p2();
        host_wr(6'h00, 32'h1);
        repeat (20) @(negedge clk);
        check("R3 still busy", host_rdata, 32'd1);
        host_wr(6'h00, 32'h1);                               // R3 ignored start
        wait_done("R10 done p2");
        check("R3 R8 p2 writes seen", exp_q.size(), 32'd0);

        // code write outside LOAD is ignored
        host_wr({1'b1, 5'd0}, {6'h3F, 26'd0});               // R2
        expect_p2();
        host_wr(6'h00, 32'h1);
        check("R3 done cleared on restart", {31'd0, done}, 32'd0);
        wait_done("R2 done rerun");
        check("R2 code unchanged", exp_q.size(), 32'd0);

        // code write inside LOAD takes effect
        host_wr(6'h00, 32'h2);
        host_wr({1'b1, 5'd0}, {6'h3F, 26'd0});
        host_wr(6'h00, 32'h1);
        wait_done("R2 done after reload");
        check("R2 no writes after reload", exp_q.size(), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule